// File: doc/BRIEF.md
# Double-Buffered Filter Coefficient Bank

This block holds the coefficients of a chain of programmable biquad filters in two complete banks, A and B. In adaptive mode the audio datapath reads one bank while a byte-wide host register port fills the other. A host request exchanges the two banks, and the exchange happens only at the next audio frame boundary. A frame is therefore never filtered with a mix of old and new coefficients.

Every coefficient is a 16-bit two's-complement word kept as two byte registers. The host writes the high byte and then the low byte. The word reaches the bank only when the low byte completes the pair, so a half-written value is never seen. A control register at address 1 holds the adaptive enable, the read-only active-bank flag and the self-clearing swap request. The datapath side takes a biquad index and a coefficient index and returns the selected signed word from its bank without a register stage.

Top module: `coef_pingpong`

## Requirements
- R1: After reset the control register reads 0x00, and in both banks each biquad's N0 is 0x7FFF while its other four coefficients are 0x0000.
- R2: The control register is at address 1. Bit 2 is the adaptive enable, bit 1 is the active-bank flag and bit 0 is the swap request. Bits 7..3 read 0, and a host write to bit 1 has no effect.
- R3: With the enable at 1 and the flag at 0, the datapath reads bank A and the host accesses bank B. With the flag at 1 the two sides exchange. With the enable at 0, both sides use bank A.
- R4: A pending swap request exchanges the banks on a cycle where frame_tick is 1 and the enable is 1. Without a frame_tick the request stays pending. A control write that sets the request, made in the same cycle as frame_tick, swaps on that boundary.
- R5: When the exchange takes place, the swap bit clears itself and the flag toggles exactly once. A frame_tick with no request pending leaves the flag unchanged.
- R6: While the enable is 0, a swap request stays pending through any frame_tick. It takes effect at the first frame_tick after the enable is set.
- R7: Biquad b, coefficient c (0=N0, 1=N1, 2=N2, 3=D1, 4=D2) has its high byte at address 2+10*b+2*c and its low byte at the next address. The datapath selects the same word with dp_biquad=b and dp_coef_sel=c.
- R8: A high-byte write alone does not change the stored word. The word is committed by a low-byte write that immediately follows the high byte of the same coefficient. A low byte with no matching pending high byte is ignored, and any other write in between cancels the pending high byte.
- R9: Address 0, and addresses at or beyond 2+10*NUM_BQ, ignore writes and read as 0. A datapath index that is out of range returns 0.
- R10: The full signed range is kept. A word written as 0x8000 is read as -32768 and a word written as 0x7FFF is read as 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host byte write strobe |
| host_addr | input | 8 | Page-local register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Combinational read byte for host_addr |
| frame_tick | input | 1 | One-cycle audio frame boundary strobe |
| dp_biquad | input | 2 | Datapath biquad index |
| dp_coef_sel | input | 3 | Datapath coefficient index (0..4) |
| dp_coef | output | 16 | Signed coefficient from the datapath bank |

## Verification
The assertions assume that frame_tick is a single-cycle pulse. They also assume that host_addr and host_wdata are steady while host_wr_en is high, and that the host completes each coefficient as two back-to-back writes. The bench drives every input on the falling edge, one host transaction at a time. It samples the combinational read ports shortly after it sets their inputs. Ordering faults are created deliberately through the normal write port: a lone high byte, a low byte to a different slot, and a control write between the two bytes of a pair. The bench sweeps every coefficient of both banks through the host port and through the datapath port.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
    localparam int COEF_W        = 16;
    localparam int BYTE_W        = 8;
    localparam int COEFS_PER_BQ  = 5;
    localparam int CTL_EN_BIT    = 2;
    localparam int CTL_FLAG_BIT  = 1;
    localparam int CTL_SWAP_BIT  = 0;

    // pass-through default: leading numerator unity, everything else zero
    function automatic logic [COEF_W-1:0] coef_reset(input int slot);
        return ((slot % COEFS_PER_BQ) == 0) ? 16'h7FFF : 16'h0000;
    endfunction
endpackage

// File: rtl/coef_store.sv
module coef_store
    import coef_bank_pkg::*;
#(
    parameter int NWORDS = 15,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wr_bank,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              host_bank,
    input  logic [SLOT_W-1:0] host_slot,
    output logic [COEF_W-1:0] host_word,
    input  logic              dp_bank,
    input  logic [SLOT_W-1:0] dp_slot,
    output logic [COEF_W-1:0] dp_word
);
    logic [1:0][NWORDS-1:0][COEF_W-1:0] mem_d, mem_q;
    logic [NWORDS-1:0][COEF_W-1:0]      rst_vals;

    for (genvar w = 0; w < NWORDS; w++) begin : g_rst
        assign rst_vals[w] = coef_reset(w);
    end

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(wr_slot) < NWORDS)) begin
            mem_d[wr_bank][wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= {rst_vals, rst_vals};
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        host_word = '0;
        dp_word   = '0;
        if (int'(host_slot) < NWORDS) host_word = mem_q[host_bank][host_slot];
        if (int'(dp_slot) < NWORDS)   dp_word   = mem_q[dp_bank][dp_slot];
    end

    // R7: a committed write lands in the addressed word
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(wr_slot) < NWORDS) |=> mem_q[$past(wr_bank)][$past(wr_slot)] == $past(wr_data));

    // R3: a write never disturbs the other bank
    p_other_bank_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[!$past(wr_bank)] == $past(mem_q[!wr_bank]));
endmodule

// File: rtl/coef_host_ctrl.sv
module coef_host_ctrl
    import coef_bank_pkg::*;
#(
    parameter int NWORDS    = 15,
    parameter int SLOT_W    = 4,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 1,
    parameter int BASE_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              frame_tick,
    input  logic [COEF_W-1:0] bank_rdata,
    output logic [SLOT_W-1:0] host_slot,
    output logic              bank_we,
    output logic [COEF_W-1:0] bank_wdata,
    output logic              host_bank_sel,
    output logic              dp_bank_sel
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE_ADDR + 2 * NWORDS);

    typedef struct packed {
        logic              en;
        logic              flag;
        logic              swap;
        logic              stage_vld;
        logic [BYTE_W-1:0] stage_byte;
        logic [SLOT_W-1:0] stage_slot;
    } hstate_t;

    hstate_t st_d, st_q;
    logic    is_ctrl, is_coef, is_low, ctrl_wr;
    logic    en_eff, req_eff, swap_now;

    always_comb begin
        is_ctrl   = (addr == CTRL_A);
        is_coef   = (addr >= BASE_A) && (addr < END_A);
        is_low    = addr[0] ^ BASE_A[0];
        host_slot = SLOT_W'((addr - BASE_A) >> 1);
        ctrl_wr   = wr_en && is_ctrl;
    end

    always_comb begin
        st_d       = st_q;
        bank_we    = 1'b0;
        bank_wdata = {st_q.stage_byte, wdata};
        en_eff     = ctrl_wr ? wdata[CTL_EN_BIT]   : st_q.en;
        req_eff    = ctrl_wr ? wdata[CTL_SWAP_BIT] : st_q.swap;
        swap_now   = frame_tick && en_eff && req_eff;
        st_d.en    = en_eff;
        st_d.swap  = req_eff;
        if (swap_now) begin
            st_d.flag = ~st_q.flag;
            st_d.swap = 1'b0;
        end
        if (wr_en) begin
            if (is_coef && !is_low) begin
                st_d.stage_vld  = 1'b1;
                st_d.stage_byte = wdata;
                st_d.stage_slot = host_slot;
            end else if (is_coef && st_q.stage_vld && (st_q.stage_slot == host_slot)) begin
                bank_we        = 1'b1;
                st_d.stage_vld = 1'b0;
            end else begin
                st_d.stage_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        host_bank_sel = st_q.en ? ~st_q.flag : 1'b0;
        dp_bank_sel   = st_q.en ?  st_q.flag : 1'b0;
        rdata         = '0;
        if (is_ctrl) begin
            rdata[CTL_EN_BIT]   = st_q.en;
            rdata[CTL_FLAG_BIT] = st_q.flag;
            rdata[CTL_SWAP_BIT] = st_q.swap;
        end else if (is_coef) begin
            rdata = is_low ? bank_rdata[BYTE_W-1:0] : bank_rdata[COEF_W-1:BYTE_W];
        end
    end

    // R4: the flag moves only on a frame boundary
    p_flag_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(st_q.flag));

    // R5: a performed swap clears the request and toggles the flag once
    p_swap_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && st_q.en && st_q.swap && !ctrl_wr) |=> (!st_q.swap && st_q.flag != $past(st_q.flag)));

    // R6: a request is held while adaptive mode is off
    p_pending_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.swap && !st_q.en && !ctrl_wr) |=> st_q.swap);

    // R8: a commit requires a matching staged high byte
    p_commit_pairs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> (st_q.stage_vld && st_q.stage_slot == host_slot && is_low));

    // R2: reserved control bits read zero
    p_ctrl_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl |-> rdata[7:3] == 5'd0);

    // R9: reserved addresses read zero
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ctrl && !is_coef) |-> rdata == '0);
endmodule

// File: rtl/coef_pingpong.sv
module coef_pingpong
    import coef_bank_pkg::*;
#(
    parameter int NUM_BQ    = 3,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 1,
    parameter int BASE_ADDR = 2,
    parameter int BQ_W      = (NUM_BQ > 1) ? $clog2(NUM_BQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr_en,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [BYTE_W-1:0]        host_wdata,
    output logic [BYTE_W-1:0]        host_rdata,
    input  logic                     frame_tick,
    input  logic [BQ_W-1:0]          dp_biquad,
    input  logic [2:0]               dp_coef_sel,
    output logic signed [COEF_W-1:0] dp_coef
);
    localparam int NWORDS = NUM_BQ * COEFS_PER_BQ;
    localparam int SLOT_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    logic [SLOT_W-1:0] host_slot, dp_slot;
    logic              bank_we, host_bank_sel, dp_bank_sel, dp_valid;
    logic [COEF_W-1:0] bank_wdata, host_word, dp_word;

    always_comb begin
        dp_valid = (int'(dp_biquad) < NUM_BQ) && (int'(dp_coef_sel) < COEFS_PER_BQ);
        dp_slot  = SLOT_W'(int'(dp_biquad) * COEFS_PER_BQ + int'(dp_coef_sel));
        dp_coef  = dp_valid ? $signed(dp_word) : '0;
    end

    coef_host_ctrl #(
        .NWORDS(NWORDS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
        .CTRL_ADDR(CTRL_ADDR), .BASE_ADDR(BASE_ADDR)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
        .wdata(host_wdata), .rdata(host_rdata), .frame_tick(frame_tick),
        .bank_rdata(host_word), .host_slot(host_slot), .bank_we(bank_we),
        .bank_wdata(bank_wdata), .host_bank_sel(host_bank_sel),
        .dp_bank_sel(dp_bank_sel)
    );

    coef_store #(.NWORDS(NWORDS), .SLOT_W(SLOT_W)) store_i (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .wr_bank(host_bank_sel),
        .wr_slot(host_slot), .wr_data(bank_wdata), .host_bank(host_bank_sel),
        .host_slot(host_slot), .host_word(host_word), .dp_bank(dp_bank_sel),
        .dp_slot(dp_slot), .dp_word(dp_word)
    );

    // R9: out-of-range datapath index yields zero
    p_dp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_valid |-> dp_coef == '0);
endmodule

// File: tb/coef_pingpong_tb.sv
module coef_pingpong_tb_top;
    logic        clk = 0, rst_n = 0, host_wr_en = 0, frame_tick = 0;
    logic [7:0]  host_addr = 0, host_wdata = 0, host_rdata;
    logic [1:0]  dp_biquad = 0;
    logic [2:0]  dp_coef_sel = 0;
    logic signed [15:0] dp_coef;
    int n_tests = 0, n_fail = 0;
    logic [15:0] exp_a [15];
    logic [15:0] exp_b [15];

    always #5 clk = ~clk;

    coef_pingpong dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .frame_tick(frame_tick),
        .dp_biquad(dp_biquad), .dp_coef_sel(dp_coef_sel), .dp_coef(dp_coef)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1; frame_tick = 1;
        @(negedge clk);
        host_wr_en = 0; frame_tick = 0;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; #1; d = host_rdata;
    endtask

    task automatic dp(input int b, input int c, output logic [15:0] d);
        @(negedge clk); dp_biquad = 2'(b); dp_coef_sel = 3'(c); #1; d = dp_coef;
    endtask

    task automatic put(input int slot, input logic [15:0] v);
        wr(8'(2 + 2 * slot), v[15:8]);
        wr(8'(3 + 2 * slot), v[7:0]);
    endtask

    function automatic logic [15:0] rstv(input int slot);
        return (slot % 5 == 0) ? 16'h7FFF : 16'h0000;
    endfunction

    task automatic host_sweep(input string tag, input logic [15:0] e [15]);
        logic [7:0] h, l;
        for (int s = 0; s < 15; s++) begin
            rd(8'(2 + 2 * s), h); rd(8'(3 + 2 * s), l);
            check(tag, {h, l}, e[s]);
        end
    endtask

    task automatic dp_sweep(input string tag, input logic [15:0] e [15]);
        logic [15:0] v;
        for (int b = 0; b < 3; b++)
            for (int c = 0; c < 5; c++) begin
                dp(b, c, v);
                check(tag, v, e[b * 5 + c]);
            end
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] v;
        for (int s = 0; s < 15; s++) begin exp_a[s] = rstv(s); exp_b[s] = rstv(s); end
        repeat (3) @(negedge clk);
        rst_n = 1;

        rd(8'd1, r); check("R1 ctrl reset", {8'h0, r}, 16'h0000);
        dp_sweep("R1 R7 dp bank A reset", exp_a);
        host_sweep("R1 host bank A reset (disabled)", exp_a);

        // R9 reserved addresses
        wr(8'd0, 8'hFF); wr(8'd32, 8'hFF); wr(8'd40, 8'hAB);
        rd(8'd0, r);   check("R9 read addr 0", {8'h0, r}, 16'h0);
        rd(8'd32, r);  check("R9 read addr 32", {8'h0, r}, 16'h0);
        rd(8'd255, r); check("R9 read addr 255", {8'h0, r}, 16'h0);
        rd(8'd1, r);   check("R9 ctrl untouched", {8'h0, r}, 16'h0);
        dp(3, 0, v); check("R9 dp biquad 3", v, 16'h0);
        for (int c = 5; c < 8; c++) begin dp(0, c, v); check("R9 dp coef sel", v, 16'h0); end

        // R2 control layout
        wr(8'd1, 8'h04); rd(8'd1, r); check("R2 enable bit", {8'h0, r}, 16'h0004);
        wr(8'd1, 8'hFE); rd(8'd1, r); check("R2 flag read-only, reserved zero", {8'h0, r}, 16'h0004);
        host_sweep("R1 host bank B reset", exp_b);

        // R3 R7 fill bank B
        for (int s = 0; s < 15; s++) begin
            exp_b[s] = 16'h4000 + 16'(s * 16'h0321) + 16'(s * 16'h0047);
            put(s, exp_b[s]);
        end
        host_sweep("R7 host bank B pattern", exp_b);
        dp_sweep("R3 dp still bank A", exp_a);

        // R8 ordering
        wr(8'd2, 8'h12); host_sweep("R8 lone high byte", exp_b);
        wr(8'd5, 8'h34); host_sweep("R8 low byte other slot", exp_b);
        wr(8'd3, 8'h56); host_sweep("R8 low byte no pending", exp_b);
        wr(8'd2, 8'h12); wr(8'd1, 8'h04); wr(8'd3, 8'h56);
        host_sweep("R8 ctrl write cancels pair", exp_b);
        put(0, 16'h1256); exp_b[0] = 16'h1256;
        host_sweep("R8 proper pair commits", exp_b);

        // R4 R5 deferred swap
        wr(8'd1, 8'h05);
        repeat (4) @(negedge clk);
        rd(8'd1, r); check("R4 request pending no tick", {8'h0, r}, 16'h0005);
        dp_sweep("R4 no swap before tick", exp_a);
        tick();
        rd(8'd1, r); check("R5 swap clears, flag set", {8'h0, r}, 16'h0006);
        dp_sweep("R3 dp bank B after swap", exp_b);
        host_sweep("R3 host bank A after swap", exp_a);

        // R10 extremes into bank A
        for (int s = 0; s < 15; s++) begin
            exp_a[s] = 16'hA000 ^ 16'(s * 16'h1111);
        end
        exp_a[0] = 16'h8000; exp_a[1] = 16'h7FFF;
        for (int s = 0; s < 15; s++) put(s, exp_a[s]);
        host_sweep("R7 host bank A pattern", exp_a);

        wr_tick(8'd1, 8'h05);
        rd(8'd1, r); check("R4 same-cycle request swaps", {8'h0, r}, 16'h0004);
        dp_sweep("R3 dp bank A after same-cycle swap", exp_a);
        dp(0, 0, v); check("R10 min value", v, 16'h8000);
        n_tests++; if ($signed(v) != -32768) begin n_fail++; $display("FAIL R10 signed min actual=%0d expected=-32768", $signed(v)); end
        dp(0, 1, v); n_tests++; if ($signed(v) != 32767) begin n_fail++; $display("FAIL R10 signed max actual=%0d expected=32767", $signed(v)); end
        tick();
        rd(8'd1, r); check("R5 tick without request", {8'h0, r}, 16'h0004);

        // R6 disabled mode
        wr(8'd1, 8'h05); tick();
        rd(8'd1, r); check("R5 flag to 1", {8'h0, r}, 16'h0006);
        wr(8'd1, 8'h01);
        rd(8'd1, r); check("R6 disabled pending", {8'h0, r}, 16'h0003);
        dp_sweep("R3 disabled dp uses A", exp_a);
        host_sweep("R3 disabled host uses A", exp_a);
        tick(); tick();
        rd(8'd1, r); check("R6 tick ignored while disabled", {8'h0, r}, 16'h0003);
        wr(8'd1, 8'h05);
        rd(8'd1, r); check("R6 enabled, still pending", {8'h0, r}, 16'h0007);
        dp_sweep("R6 dp bank B before tick", exp_b);
        tick();
        rd(8'd1, r); check("R6 swap after enable", {8'h0, r}, 16'h0004);
        dp_sweep("R6 dp bank A after tick", exp_a);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule